// File: doc/BRIEF.md
# Oscillator Band Autoselect Search Controller

This block chooses one of 24 oscillator bands for a frequency synthesizer. When the coarse divider's low byte is written while automatic selection is on, it starts from the band held in the manual band field. It then steps through adjacent bands, one at a time. After each band change it waits a programmable settling time and then samples a 3-bit tuning-voltage code from an external converter. The search ends with success as soon as the code shows the voltage sitting in the narrow preferred window. It ends with failure if it runs into the bottom or top band, or if it uses up its step budget.

The block presents the active band index to the oscillator bank and the read strobe to the converter. For the status registers it reports a busy flag, a done flag, a success flag, a band readback and a converter-code readback. With automatic selection off, the band follows the manual field directly, the converter read strobe follows a software enable bit, and a latch bit captures the present code into the readback.

Top module: `vco_band_search`

## Requirements
- R1: After reset: busy=0, done=1, success=0, band_sel=12, band_rb=0, adc_rb=0, automatic selection enabled, read enable bit 0.
- R2: A search starts only on a write to address 0x1 while the autoselect bit is 1. Writes to other addresses, or to 0x1 while autoselect is 0, leave busy at 0.
- R3: Address 0x7 holds the band control: bits [7:3] = manual band (values above 23 are clamped to 23), bit 2 = autoselect enable, bit 1 = latch, bit 0 = read enable.
- R4: In the cycle after a trigger: busy=1, done=0, success=0, and the probed band equals the manual band.
- R5: Each probed band takes settle_cycles+2 clock cycles, and adc_rd_en is high for exactly one of those cycles. With P probes, done rises P*(settle_cycles+2) edges after the trigger edge.
- R6: A sampled code of 010 or 101 ends the search: done=1, success=1, busy=0, band_rb = that band, adc_rb = that code.
- R7: A code with MSB 0 (000, 001) moves the search one band down. A code with MSB 1 (110, 111) moves it one band up.
- R8: A move down from band 0 or a move up from band 23 ends the search with done=1, success=0, and band_rb = the last probed band.
- R9: The 24th sample without a window code ends the search with done=1 and success=0.
- R10: A new trigger during a search restarts it from the current manual field. A write to 0x7 with autoselect 0 during a search aborts it (busy=0, done=1, success=0).
- R11: With autoselect 0, band_sel equals the manual band, adc_rd_en equals the read enable bit, and a write to 0x7 with bit 1 set and bit 2 clear captures adc_code into adc_rb.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 8 | Register write data |
| settle_cycles | input | 8 | Settling wait per band, in cycles |
| adc_code | input | 3 | Tuning-voltage converter code |
| adc_rd_en | output | 1 | Converter read strobe |
| band_sel | output | 5 | Active oscillator band |
| busy | output | 1 | Search running |
| done | output | 1 | No search running (done flag) |
| success | output | 1 | Last search found a window band |
| band_rb | output | 5 | Band readback from the last search |
| adc_rb | output | 3 | Captured converter code |

## Verification
A wrong band pointer appears at band_sel within one cycle of the move. It also shows up as a wrong final band_rb and a done edge at the wrong time. A miscounted settle or step counter shifts the done edge by a whole probe period, or changes how many read strobes are issued, so the bench measures the exact latency in cycles and counts the strobes. A wrong direction or edge decision leaves the search at the wrong band or flips success. The bench models the converter as a function of band_sel, so any such error shows at the ports at the end of the search at the latest.

// File: rtl/vcs_pkg.sv
package vcs_pkg;
    localparam int ADDR_W    = 4;
    localparam int TRIG_ADDR = 1;
    localparam int VCO_ADDR  = 7;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETTLE = 2'd1,
        ST_SAMPLE = 2'd2
    } srch_st_e;

    function automatic logic code_in_window(input logic [2:0] c);
        return (c == 3'b010) || (c == 3'b101);
    endfunction
endpackage

// File: rtl/vcs_cfg_regs.sv
module vcs_cfg_regs #(
    parameter int NUM_BANDS  = 24,
    parameter int RESET_BAND = 12,
    localparam int BAND_W    = $clog2(NUM_BANDS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [vcs_pkg::ADDR_W-1:0] wr_addr,
    input  logic [7:0]                 wr_data,
    output logic [BAND_W-1:0]          man_band,
    output logic                       auto_en,
    output logic                       rd_en_bit,
    output logic                       start,
    output logic                       cancel,
    output logic                       latch
);
    typedef struct packed {
        logic [BAND_W-1:0] man;
        logic              vas;
        logic              ade;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic vco_wr;
    logic [BAND_W-1:0] field;

    always_comb begin
        cfg_d  = cfg_q;
        vco_wr = wr_en && (wr_addr == vcs_pkg::ADDR_W'(vcs_pkg::VCO_ADDR));
        field  = wr_data[7 -: BAND_W];
        if (vco_wr) begin
            cfg_d.man = (int'(field) > NUM_BANDS - 1) ? BAND_W'(NUM_BANDS - 1) : field;
            cfg_d.vas = wr_data[2];
            cfg_d.ade = wr_data[0];
        end
        start  = wr_en && (wr_addr == vcs_pkg::ADDR_W'(vcs_pkg::TRIG_ADDR)) && cfg_q.vas;
        cancel = vco_wr && !wr_data[2];
        latch  = vco_wr && !wr_data[2] && wr_data[1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.man <= BAND_W'(RESET_BAND);
            cfg_q.vas <= 1'b1;
            cfg_q.ade <= 1'b0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign man_band  = cfg_q.man;
    assign auto_en   = cfg_q.vas;
    assign rd_en_bit = cfg_q.ade;

    // R3
    man_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cfg_q.man) <= NUM_BANDS - 1);
endmodule

// File: rtl/vcs_search_fsm.sv
module vcs_search_fsm #(
    parameter int NUM_BANDS  = 24,
    parameter int SETTLE_W   = 8,
    parameter int RESET_BAND = 12,
    localparam int BAND_W    = $clog2(NUM_BANDS),
    localparam int STEP_W    = $clog2(NUM_BANDS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                cancel,
    input  logic                latch,
    input  logic                auto_en,
    input  logic                rd_en_bit,
    input  logic [BAND_W-1:0]   man_band,
    input  logic [SETTLE_W-1:0] settle_cycles,
    input  logic [2:0]          adc_code,
    output logic                adc_rd_en,
    output logic [BAND_W-1:0]   band_sel,
    output logic                busy,
    output logic                done,
    output logic                success,
    output logic [BAND_W-1:0]   band_rb,
    output logic [2:0]          adc_rb
);
    import vcs_pkg::*;

    typedef struct packed {
        srch_st_e          st;
        logic [BAND_W-1:0] cur;
        logic [SETTLE_W-1:0] cnt;
        logic [STEP_W-1:0] steps;
        logic              busy;
        logic              done;
        logic              ok;
        logic [BAND_W-1:0] band_rb;
        logic [2:0]        adc_rb;
    } srch_t;

    srch_t s_d, s_q;
    logic              go_up, at_edge, sampling;
    logic [STEP_W-1:0] k;

    always_comb begin
        s_d      = s_q;
        sampling = 1'b0;
        go_up    = adc_code[2];
        at_edge  = go_up ? (s_q.cur == BAND_W'(NUM_BANDS - 1)) : (s_q.cur == '0);
        k        = s_q.steps + STEP_W'(1);
        if (latch) s_d.adc_rb = adc_code;
        if (cancel && s_q.busy) begin
            s_d.st   = ST_IDLE;
            s_d.busy = 1'b0;
            s_d.done = 1'b1;
            s_d.ok   = 1'b0;
        end else if (start) begin
            s_d.st    = ST_SETTLE;
            s_d.cur   = man_band;
            s_d.cnt   = settle_cycles;
            s_d.steps = '0;
            s_d.busy  = 1'b1;
            s_d.done  = 1'b0;
            s_d.ok    = 1'b0;
        end else begin
            unique case (s_q.st)
                ST_SETTLE: begin
                    if (s_q.cnt == '0) s_d.st = ST_SAMPLE;
                    else s_d.cnt = s_q.cnt - SETTLE_W'(1);
                end
                ST_SAMPLE: begin
                    sampling     = 1'b1;
                    s_d.adc_rb   = adc_code;
                    if (code_in_window(adc_code) || at_edge || k == STEP_W'(NUM_BANDS)) begin
                        s_d.st      = ST_IDLE;
                        s_d.busy    = 1'b0;
                        s_d.done    = 1'b1;
                        s_d.ok      = code_in_window(adc_code);
                        s_d.band_rb = s_q.cur;
                    end else begin
                        s_d.cur   = go_up ? s_q.cur + BAND_W'(1) : s_q.cur - BAND_W'(1);
                        s_d.steps = k;
                        s_d.cnt   = settle_cycles;
                        s_d.st    = ST_SETTLE;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.st      <= ST_IDLE;
            s_q.cur     <= BAND_W'(RESET_BAND);
            s_q.cnt     <= '0;
            s_q.steps   <= '0;
            s_q.busy    <= 1'b0;
            s_q.done    <= 1'b1;
            s_q.ok      <= 1'b0;
            s_q.band_rb <= '0;
            s_q.adc_rb  <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign band_sel  = auto_en ? s_q.cur : man_band;
    assign adc_rd_en = auto_en ? sampling : rd_en_bit;
    assign busy      = s_q.busy;
    assign done      = s_q.done;
    assign success   = s_q.ok;
    assign band_rb   = s_q.band_rb;
    assign adc_rb    = s_q.adc_rb;

    // R4
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(s_q.busy && s_q.done));
    // R6
    success_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.ok |-> s_q.done);
    // R8
    band_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(s_q.cur) <= NUM_BANDS - 1);
    // R4
    done_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(s_q.done) |-> s_q.busy);
    // R5
    settle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_SETTLE && !start) |=> $stable(s_q.cur));
    // R9
    step_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(s_q.steps) <= NUM_BANDS - 1);
endmodule

// File: rtl/vco_band_search.sv
module vco_band_search #(
    parameter int NUM_BANDS  = 24,
    parameter int SETTLE_W   = 8,
    parameter int RESET_BAND = 12,
    localparam int BAND_W    = $clog2(NUM_BANDS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [vcs_pkg::ADDR_W-1:0] wr_addr,
    input  logic [7:0]                 wr_data,
    input  logic [SETTLE_W-1:0]        settle_cycles,
    input  logic [2:0]                 adc_code,
    output logic                       adc_rd_en,
    output logic [BAND_W-1:0]          band_sel,
    output logic                       busy,
    output logic                       done,
    output logic                       success,
    output logic [BAND_W-1:0]          band_rb,
    output logic [2:0]                 adc_rb
);
    logic [BAND_W-1:0] man_band;
    logic auto_en, rd_en_bit, start, cancel, latch;

    vcs_cfg_regs #(.NUM_BANDS(NUM_BANDS), .RESET_BAND(RESET_BAND)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .man_band(man_band), .auto_en(auto_en),
        .rd_en_bit(rd_en_bit), .start(start), .cancel(cancel), .latch(latch)
    );

    vcs_search_fsm #(.NUM_BANDS(NUM_BANDS), .SETTLE_W(SETTLE_W),
                     .RESET_BAND(RESET_BAND)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .cancel(cancel), .latch(latch),
        .auto_en(auto_en), .rd_en_bit(rd_en_bit), .man_band(man_band),
        .settle_cycles(settle_cycles), .adc_code(adc_code), .adc_rd_en(adc_rd_en),
        .band_sel(band_sel), .busy(busy), .done(done), .success(success),
        .band_rb(band_rb), .adc_rb(adc_rb)
    );
endmodule

// File: tb/vco_band_search_tb.sv
module vco_band_search_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] settle = '0;
    logic [2:0] adc_code;
    logic       adc_rd_en, busy, done, success;
    logic [4:0] band_sel, band_rb;
    logic [2:0] adc_rb;

    int n_chk = 0, n_bad = 0, cyc = 0;
    int mode = 0, target = 0;
    logic alt_code = 1'b0;
    logic [2:0] const_code = 3'b000;

    always #(CLK_PERIOD/2) clk = ~clk;

    vco_band_search u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .settle_cycles(settle), .adc_code(adc_code), .adc_rd_en(adc_rd_en),
        .band_sel(band_sel), .busy(busy), .done(done), .success(success),
        .band_rb(band_rb), .adc_rb(adc_rb)
    );

    function automatic logic [2:0] adc_model(input logic [4:0] b);
        int d;
        if (mode == 1) return b[0] ? 3'b110 : 3'b001;
        if (mode == 2) return const_code;
        d = int'(b) - target;
        if (d < -1) return 3'b111;
        if (d == -1) return 3'b110;
        if (d == 0) return alt_code ? 3'b101 : 3'b010;
        if (d == 1) return 3'b001;
        return 3'b000;
    endfunction

    assign adc_code = adc_model(band_sel);

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: act=%0d cycles exp<=150000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 4'(a); wr_data = 8'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic int vco_word(input int band, input int vas, input int adl, input int ade);
        return (band << 3) | (vas << 2) | (adl << 1) | ade;
    endfunction

    int lat, rds;
    task automatic run_search(output int l, output int r);
        wr(1, 8'hB6);
        l = 0; r = 0;
        while (!done && l < 2000) begin
            @(negedge clk);
            l++;
            if (adc_rd_en) r++;
        end
    endtask

    task automatic rand_case(input int st, input int tg, input int s, input logic alt);
        int e_ok, e_band, e_probes;
        mode = 0; target = tg; alt_code = alt; settle = 8'(s);
        if (tg >= 0 && tg <= 23) begin
            e_ok = 1; e_band = tg; e_probes = (st > tg ? st - tg : tg - st) + 1;
        end else if (tg < 0) begin
            e_ok = 0; e_band = 0; e_probes = st + 1;
        end else begin
            e_ok = 0; e_band = 23; e_probes = 24 - st;
        end
        wr(7, vco_word(st, 1, 0, 0));
        run_search(lat, rds);
        check(e_ok ? "R6 success" : "R8 edge fail", int'(success), e_ok);
        check("R6/R8 band_rb", int'(band_rb), e_band);
        check("R5 latency", lat, e_probes * (s + 2));
        check("R5 read strobes", rds, e_probes);
        check("R7 busy low at end", int'(busy), 0);
        if (e_ok) check("R6 adc_rb", int'(adc_rb), alt ? 5 : 2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check("R1 busy", int'(busy), 0);
        check("R1 done", int'(done), 1);
        check("R1 success", int'(success), 0);
        check("R1 band_sel", int'(band_sel), 12);
        check("R1 band_rb", int'(band_rb), 0);
        check("R1 adc_rb", int'(adc_rb), 0);
        check("R1 rd_en", int'(adc_rd_en), 0);

        // R2: other addresses do not trigger
        mode = 0; target = 5; settle = 8'd1;
        wr(0, 8'h03);
        wr(5, 8'h04);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check("R2 no trigger other addr", int'(busy), 0);
        end

        // R4: trigger start state
        wr(7, vco_word(9, 1, 0, 0));
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 4'd1; wr_data = 8'h10;
        @(negedge clk);
        wr_en = 1'b0;
        check("R4 busy", int'(busy), 1);
        check("R4 done", int'(done), 0);
        check("R4 success", int'(success), 0);
        check("R4 start band", int'(band_sel), 9);
        while (!done) @(negedge clk);
        check("R6 band_rb directed", int'(band_rb), 5);

        // R9: oscillating codes exhaust step budget
        mode = 1; settle = 8'd0;
        wr(7, vco_word(10, 1, 0, 0));
        run_search(lat, rds);
        check("R9 fail", int'(success), 0);
        check("R9 done", int'(done), 1);
        check("R9 latency", lat, 24 * 2);
        check("R9 band_rb", int'(band_rb), 9);

        // R8: directed edges
        rand_case(0, -1, 2, 1'b0);
        rand_case(23, 24, 2, 1'b0);
        rand_case(0, 23, 0, 1'b1);

        // R10: restart from new manual field
        mode = 0; target = 20; settle = 8'd3; alt_code = 1'b0;
        wr(7, vco_word(5, 1, 0, 0));
        wr(1, 0);
        repeat (3) @(negedge clk);
        wr(7, vco_word(18, 1, 0, 0));
        check("R10 still busy", int'(busy), 1);
        run_search(lat, rds);
        check("R10 restart latency", lat, 3 * 5);
        check("R10 restart band", int'(band_rb), 20);
        check("R10 restart success", int'(success), 1);

        // R10: abort
        target = 2;
        wr(7, vco_word(20, 1, 0, 0));
        wr(1, 0);
        repeat (5) @(negedge clk);
        wr(7, vco_word(4, 0, 0, 1));
        check("R10 abort busy", int'(busy), 0);
        check("R10 abort done", int'(done), 1);
        check("R10 abort success", int'(success), 0);

        // R11: manual mode
        check("R11 band follows", int'(band_sel), 4);
        check("R11 rd_en = bit", int'(adc_rd_en), 1);
        wr(7, vco_word(30, 0, 0, 0));
        check("R3 clamp", int'(band_sel), 23);
        check("R11 rd_en off", int'(adc_rd_en), 0);
        mode = 2; const_code = 3'b011;
        wr(7, vco_word(7, 0, 1, 1));
        check("R11 latch", int'(adc_rb), 3);
        wr(1, 0);
        repeat (3) begin
            @(negedge clk);
            check("R2 no trigger when disabled", int'(busy), 0);
        end

        // random
        void'($urandom(32'd1234));
        for (int i = 0; i < 40; i++) begin
            rand_case(int'($urandom_range(0, 23)), int'($urandom_range(0, 29)) - 3,
                      int'($urandom_range(0, 5)), 1'($urandom_range(0, 1)));
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule